// File: doc/BRIEF.md
# Guarded Sleep Monitor-Disable Control

This block holds an 8-bit control register in which one protected bit lets software switch off a supply-monitor circuit for the next sleep. Software cannot set that bit with one write. It first writes an unlock pattern, which opens a short window. It then writes a set pattern inside that window.

Once the bit is set, it passes through a pending phase and then an active phase, after which it clears itself. A sleep request that arrives during the active phase raises the monitor-off output. The output stays high until a wake input is seen. The other register bits are plain storage.

Timing terms used below: edge t is the rising clock edge that samples the unlock write, and edge s is the rising edge that samples an accepted set write. Readback is combinational, so a value "after edge n" is visible until edge n+1.

Top module: `sleep_guard_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `mon_off` is 0.
- R2: Register bits 7 and 4..0 are plain storage. Every write loads them from `wr_data`, and no unlock or set activity changes them.
- R3: A write with bit 6 = 1 and bit 5 = 1 is an unlock write. It opens a window of 4 cycles: bit 5 reads 1 after edges t..t+3 and reads 0 after edge t+4, unless a write closes the window earlier.
- R4: A write with bit 6 = 1 and bit 5 = 0 is a set write. It is accepted when it lands on edge t+1, t+2, t+3 or t+4. After acceptance, bit 6 reads 1 and bit 5 reads 0.
- R5: A set write that lands on edge t+5 or later, or that has no unlock before it, leaves bit 6 at 0.
- R6: During an open window, any write that is not an unlock write closes the window: bit 5 reads 0 after that edge. A later set write is then rejected.
- R7: After an accepted set on edge s, bit 6 reads 1 after edges s..s+5 and clears itself to 0 after edge s+6.
- R8: A `sleep_req` sampled on edge s+4, s+5 or s+6 is accepted and raises `mon_off` after that edge. A request sampled on edges s+1..s+3 (pending phase) or after the self-clear is ignored.
- R9: `mon_off` stays high until `wake` is sampled high, then reads 0 after that edge. A `sleep_req` that arrives while `mon_off` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register readback (bit 6 disable, bit 5 window) |
| sleep_req | input | 1 | Sleep request pulse |
| wake | input | 1 | Wake event; clears mon_off |
| mon_off | output | 1 | Monitor off while high |

## Verification
A wrong window counter shows up on bit 5 of the readback in the cycle after the unlock write. It also shows up one cycle after the boundary set writes at edges t+4 and t+5, where bit 6 either appears or stays clear.

A wrong phase counter shows up on `mon_off` one cycle after a sleep request placed at each edge from s+1 to s+7. It also shows up on bit 6 after edge s+6.

Corrupted plain bits show up on the readback right after the next write.

// File: rtl/sleep_guard_ctrl.sv
module sleep_guard_ctrl #(
  parameter int WIN_CYCLES = 4,
  parameter int ACT_DELAY  = 3,
  parameter int ACT_HOLD   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sleep_req,
  input  logic       wake,
  output logic       mon_off
);
  localparam int WW = $clog2(WIN_CYCLES + 1);
  localparam int AW = $clog2(ACT_DELAY + ACT_HOLD + 1);
  localparam logic [WW-1:0] WIN_LOAD = WW'(WIN_CYCLES);
  localparam logic [AW-1:0] AGE_TOP  = AW'(ACT_DELAY + ACT_HOLD);
  localparam logic [AW-1:0] AGE_ACT  = AW'(ACT_DELAY);

  logic [5:0]    plain_q;
  logic [WW-1:0] win_q;
  logic [AW-1:0] age_q;

  wire unlock_wr = wr_en && wr_data[6] && wr_data[5];
  wire set_wr    = wr_en && wr_data[6] && !wr_data[5];
  wire win_open  = (win_q != '0);
  wire set_ok    = set_wr && win_open;
  wire dis_bit   = (age_q != '0);
  wire dis_act   = (age_q > AGE_ACT);

  assign rd_data = {plain_q[5], dis_bit, win_open, plain_q[4:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) plain_q <= '0;
    else if (wr_en) plain_q <= {wr_data[7], wr_data[4:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) win_q <= '0;
    else if (unlock_wr) win_q <= WIN_LOAD;
    else if (wr_en) win_q <= '0;
    else if (win_open) win_q <= win_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age_q <= '0;
    else if (set_ok) age_q <= AW'(1);
    else if (age_q == AGE_TOP) age_q <= '0;
    else if (dis_bit) age_q <= age_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mon_off <= 1'b0;
    else if (mon_off) mon_off <= !wake;
    else mon_off <= sleep_req && dis_act;

  assert_plain_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[7] == $past(wr_data[7])) && (rd_data[4:0] == $past(wr_data[4:0])));

  assert_unlock_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_wr |=> rd_data[5]);

  assert_no_set_without_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && !rd_data[5] && !rd_data[6]) |=> !rd_data[6]);

  assert_other_write_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[6]) |=> !rd_data[5]);

  assert_rise_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_off) |-> ($past(sleep_req) && $past(rd_data[6])));

  assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_off && wake) |=> !mon_off);

  assert_hold_until_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_off && !wake) |=> mon_off);
endmodule

// File: tb/sleep_guard_ctrl_tb.sv
module sleep_guard_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sleep_req = 1'b0;
  logic wake = 1'b0;
  logic mon_off;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_guard_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake(wake), .mon_off(mon_off)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 mon_off", {7'd0, mon_off}, 8'h00);
  endtask

  task automatic t_plain();
    do_write(8'h9F);
    check("R2 plain store", rd_data, 8'h9F);
    do_write(8'h7F);
    check("R2 plain with unlock", rd_data, 8'h3F);
    idle(6);
    check("R2 plain unchanged after window", rd_data, 8'h1F);
    do_write(8'h00);
  endtask

  task automatic t_window();
    do_write(8'h60);
    idle(3);
    check("R3 window open at t+3", rd_data, 8'h20);
    idle(1);
    check("R3 window closed at t+4", rd_data, 8'h00);
  endtask

  task automatic t_set_at(input int k, input bit ok);
    do_write(8'h60);
    idle(k - 1);
    do_write(8'h40);
    if (ok) check($sformatf("R4 set at t+%0d", k), rd_data, 8'h40);
    else    check($sformatf("R5 set at t+%0d", k), rd_data, 8'h00);
    idle(10);
  endtask

  task automatic t_no_unlock();
    do_write(8'h40);
    check("R5 set without unlock", rd_data, 8'h00);
  endtask

  task automatic t_cancel();
    do_write(8'h60);
    do_write(8'h01);
    check("R6 other write closes window", rd_data, 8'h01);
    do_write(8'h40);
    check("R6 set after cancel rejected", rd_data, 8'h00);
  endtask

  task automatic t_selfclear();
    do_write(8'h60);
    do_write(8'h40);
    idle(5);
    check("R7 bit set at s+5", rd_data, 8'h40);
    idle(1);
    check("R7 self-clear at s+6", rd_data, 8'h00);
  endtask

  task automatic t_sleep_at(input int k, input bit ok);
    do_write(8'h60);
    do_write(8'h40);
    idle(k - 1);
    pulse_sleep();
    check($sformatf("R8 sleep at s+%0d", k), {7'd0, mon_off}, {7'd0, ok});
    if (mon_off) pulse_wake();
    idle(8);
  endtask

  task automatic t_hold_wake();
    do_write(8'h60);
    do_write(8'h40);
    idle(4);
    pulse_sleep();
    check("R9 mon_off raised", {7'd0, mon_off}, 8'h01);
    idle(10);
    check("R9 mon_off held", {7'd0, mon_off}, 8'h01);
    pulse_sleep();
    check("R9 sleep while high ignored", {7'd0, mon_off}, 8'h01);
    pulse_wake();
    check("R9 wake clears", {7'd0, mon_off}, 8'h00);
    idle(3);
    check("R9 stays low", {7'd0, mon_off}, 8'h00);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_plain();
    t_window();
    for (int k = 1; k <= 5; k++) t_set_at(k, k <= 4);
    t_set_at(7, 1'b0);
    t_no_unlock();
    t_cancel();
    t_selfclear();
    for (int k = 1; k <= 8; k++) t_sleep_at(k, (k >= 4) && (k <= 6));
    t_hold_wake();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule